// File: doc/BRIEF.md
# Accumulator ALU with Multi-Cycle Multiply and Divide

This block is the arithmetic unit of a small accumulator-based 8-bit controller core. Each operation is launched by a one-cycle `start_i` pulse together with an operation code, the accumulator value, the auxiliary register value, a source operand and the incoming carry. The block registers new accumulator and auxiliary values plus carry and overflow flags. It raises `done_o` for one cycle when those registered values are valid.

Most operations finish on the edge that accepts them. Unsigned multiply and divide use the accumulator and auxiliary register as a pair. They run iteratively for a fixed number of cycles. During that time `busy_o` is high, the operands latched at start are used, and further start pulses are ignored.

Between completions the registered outputs hold their values. A controller therefore reads them back as the live A, B, CY and OV state.

Top module: `acc_alu`

## Requirements
- R1: ADD (op_i=0h) gives a_o=(a_i+src_i) mod 256, cy_o=carry out of bit 7, ov_o=signed overflow, and b_o=b_i. For example FFh+01h gives 00h with cy_o=1.
- R2: SUBB (op_i=1h) gives a_o=(a_i-src_i-cy_i) mod 256, cy_o=1 when a borrow occurs, ov_o=signed overflow of the subtraction, and b_o=b_i.
- R3: AND (2h), OR (3h), XOR (4h) of a_i with src_i, complement of a_i (5h) and clear (6h) write the result to a_o. They set cy_o=cy_i and b_o=b_i, and leave ov_o at its previous value.
- R4: INC (7h) and DEC (8h) change a_i by one modulo 256. Flags and b_o follow the same rule as R3.
- R5: The rotates are RR (9h), RL (Ah), RRC (Bh) and RLC (Ch). RRC and RLC rotate through the carry, and cy_o takes the bit shifted out. SWAP (Dh) exchanges the nibbles of a_i. RR, RL and SWAP behave like R3 for flags. RRC and RLC leave ov_o unchanged.
- R6: An operation from R1 to R5 that is accepted at a clock edge gives done_o=1 and busy_o=0 in the following cycle, with its results on the outputs.
- R7: MUL (Eh) forms the 16-bit product a_i*b_i. The high byte goes to b_o and the low byte to a_o. It sets cy_o=0 and sets ov_o=1 exactly when the product exceeds FFh.
- R8: DIV (Fh) puts a_i/b_i in a_o and the remainder in b_o, with cy_o=0 and ov_o=0. For a zero divisor it gives ov_o=1, cy_o=0, a_o=FFh and b_o=the dividend.
- R9: After an accepted MUL or DIV, busy_o is high for exactly 4 cycles. done_o is high in the cycle after busy_o falls and never together with busy_o, and the results are valid in that cycle.
- R10: Operands are captured when MUL or DIV is accepted. Changes to a_i and b_i, and any start_i pulse while busy_o is high, have no effect on the results or the outputs.
- R11: After reset a_o, b_o, cy_o, ov_o, busy_o and done_o are all 0.
- R12: With no accepted start and no completion, a_o, b_o, cy_o and ov_o keep their values and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch operation (ignored while busy) |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator value |
| b_i | input | 8 | Auxiliary register value |
| src_i | input | 8 | Source operand |
| cy_i | input | 1 | Incoming carry flag |
| a_o | output | 8 | New accumulator value |
| b_o | output | 8 | New auxiliary register value |
| cy_o | output | 1 | New carry flag |
| ov_o | output | 1 | New overflow flag |
| busy_o | output | 1 | Multi-cycle operation in progress |
| done_o | output | 1 | One-cycle pulse when results are valid |

## Verification
The hardest case to create from the ports is a multi-cycle operation whose inputs are disturbed while it runs. The stimulus starts a MUL or DIV and then changes a_i and b_i on every busy cycle. It also pulses start_i with other operation codes, including on the completing edge. The result must match the operands captured at start, with no extra done pulse. Zero divisors and carry-through rotates are issued directly. A long random phase mixes every opcode with random start density so that these collisions recur.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_SUBB = 4'h1, OP_AND  = 4'h2, OP_OR   = 4'h3,
    OP_XOR  = 4'h4, OP_CPL  = 4'h5, OP_CLR  = 4'h6, OP_INC  = 4'h7,
    OP_DEC  = 4'h8, OP_RR   = 4'h9, OP_RL   = 4'hA, OP_RRC  = 4'hB,
    OP_RLC  = 4'hC, OP_SWAP = 4'hD, OP_MUL  = 4'hE, OP_DIV  = 4'hF
  } alu_op_e;

  function automatic logic is_multi(alu_op_e op);
    return (op == OP_MUL) || (op == OP_DIV);
  endfunction
endpackage

// File: rtl/acc_alu_single.sv
module acc_alu_single
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   src_i,
  input  logic           cy_i,
  output logic [W-1:0]   res_o,
  output logic           cy_o,
  output logic           ov_o,
  output logic           ov_we_o
);
  localparam int HN = W / 2;

  logic [W:0] sum_w, dif_w;

  assign sum_w = {1'b0, a_i} + {1'b0, src_i};
  assign dif_w = {1'b0, a_i} - {1'b0, src_i} - {{W{1'b0}}, cy_i};

  always_comb begin
    res_o   = a_i;
    cy_o    = cy_i;
    ov_o    = 1'b0;
    ov_we_o = 1'b0;
    unique case (op_i)
      OP_ADD: begin
        res_o   = sum_w[W-1:0];
        cy_o    = sum_w[W];
        ov_o    = (a_i[W-1] == src_i[W-1]) && (sum_w[W-1] != a_i[W-1]);
        ov_we_o = 1'b1;
      end
      OP_SUBB: begin
        res_o   = dif_w[W-1:0];
        cy_o    = dif_w[W];
        ov_o    = (a_i[W-1] != src_i[W-1]) && (dif_w[W-1] != a_i[W-1]);
        ov_we_o = 1'b1;
      end
      OP_AND:  res_o = a_i & src_i;
      OP_OR:   res_o = a_i | src_i;
      OP_XOR:  res_o = a_i ^ src_i;
      OP_CPL:  res_o = ~a_i;
      OP_CLR:  res_o = '0;
      OP_INC:  res_o = a_i + 1'b1;
      OP_DEC:  res_o = a_i - 1'b1;
      OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
      OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
      OP_RRC: begin
        res_o = {cy_i, a_i[W-1:1]};
        cy_o  = a_i[0];
      end
      OP_RLC: begin
        res_o = {a_i[W-2:0], cy_i};
        cy_o  = a_i[W-1];
      end
      OP_SWAP: res_o = {a_i[HN-1:0], a_i[W-1:HN]};
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int W      = 8,
  parameter int CYCLES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         div_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ov_o
);
  localparam int STEP = W / CYCLES;
  localparam int CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic            busy_q, div_q;
  logic [CW-1:0]   cnt_q;
  logic [2*W-1:0]  mcand_q, prod_q, mcand_d, prod_d;
  logic [W-1:0]    mplr_q, mplr_d, dvsr_q, rem_q, rem_d, quot_q, quot_d;

  // STEP bits of shift-add multiply and restoring divide per cycle
  always_comb begin
    logic [W:0] t;
    prod_d  = prod_q;
    mcand_d = mcand_q;
    mplr_d  = mplr_q;
    rem_d   = rem_q;
    quot_d  = quot_q;
    for (int i = 0; i < STEP; i++) begin
      if (mplr_d[0]) prod_d = prod_d + mcand_d;
      mcand_d = mcand_d << 1;
      mplr_d  = mplr_d >> 1;
      t       = {rem_d, quot_d[W-1]};
      quot_d  = quot_d << 1;
      if (t >= {1'b0, dvsr_q}) begin
        t         = t - {1'b0, dvsr_q};
        quot_d[0] = 1'b1;
      end
      rem_d = t[W-1:0];
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == LAST);
  assign lo_o   = div_q ? quot_d : prod_d[W-1:0];
  assign hi_o   = div_q ? rem_d  : prod_d[2*W-1:W];
  assign ov_o   = div_q ? (dvsr_q == '0) : (prod_d[2*W-1:W] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      div_q   <= 1'b0;
      cnt_q   <= '0;
      mcand_q <= '0;
      prod_q  <= '0;
      mplr_q  <= '0;
      dvsr_q  <= '0;
      rem_q   <= '0;
      quot_q  <= '0;
    end else if (busy_q) begin
      prod_q  <= prod_d;
      mcand_q <= mcand_d;
      mplr_q  <= mplr_d;
      rem_q   <= rem_d;
      quot_q  <= quot_d;
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      div_q   <= div_i;
      cnt_q   <= '0;
      mcand_q <= {{W{1'b0}}, a_i};
      prod_q  <= '0;
      mplr_q  <= b_i;
      dvsr_q  <= b_i;
      rem_q   <= '0;
      quot_q  <= a_i;
    end
  end

  assert_busy_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |=> !busy_o);
  assert_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && cnt_q == '0));
  assert_operand_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fin_o) |=> ($stable(dvsr_q) && $stable(div_q)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W      = 8,
  parameter int CYCLES = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] src_i,
  input  logic         cy_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         cy_o,
  output logic         ov_o,
  output logic         busy_o,
  output logic         done_o
);
  alu_op_e      op;
  logic         accept, multi;
  logic [W-1:0] s_res, md_lo, md_hi;
  logic         s_cy, s_ov, s_ov_we, md_busy, md_fin, md_ov;
  logic [W-1:0] a_q, b_q;
  logic         cy_q, ov_q, done_q;

  assign op     = alu_op_e'(op_i);
  assign multi  = is_multi(op);
  assign accept = start_i && !md_busy;

  acc_alu_single #(.W(W)) u_single (
    .op_i(op), .a_i(a_i), .src_i(src_i), .cy_i(cy_i),
    .res_o(s_res), .cy_o(s_cy), .ov_o(s_ov), .ov_we_o(s_ov_we)
  );

  acc_alu_muldiv #(.W(W), .CYCLES(CYCLES)) u_muldiv (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(accept && multi), .div_i(op == OP_DIV),
    .a_i(a_i), .b_i(b_i),
    .busy_o(md_busy), .fin_o(md_fin),
    .lo_o(md_lo), .hi_o(md_hi), .ov_o(md_ov)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      cy_q   <= 1'b0;
      ov_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (md_fin) begin
        a_q    <= md_lo;
        b_q    <= md_hi;
        cy_q   <= 1'b0;
        ov_q   <= md_ov;
        done_q <= 1'b1;
      end else if (accept && !multi) begin
        a_q    <= s_res;
        b_q    <= b_i;
        cy_q   <= s_cy;
        if (s_ov_we) ov_q <= s_ov;
        done_q <= 1'b1;
      end
    end
  end

  assign a_o    = a_q;
  assign b_o    = b_q;
  assign cy_o   = cy_q;
  assign ov_o   = ov_q;
  assign busy_o = md_busy;
  assign done_o = done_q;

  assert_single_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !multi) |=> (done_o && !busy_o));
  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  assert_md_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_fin |=> (done_o && !cy_o));
  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept && !md_fin) |=> (!done_o && $stable(a_o) && $stable(b_o)
                              && $stable(cy_o) && $stable(ov_o)));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] a = '0, b = '0, src = '0;
  logic       cy = 1'b0;
  logic [7:0] a_o, b_o;
  logic       cy_o, ov_o, busy_o, done_o;

  int vectors = 0, fails = 0;
  bit finished = 0;

  // reference state
  int e_a = 0, e_b = 0, e_cy = 0, e_ov = 0, e_busy = 0, e_done = 0;
  int rem = 0, m_op = 0, m_a = 0, m_b = 0;
  string tag = "R11";

  always #10 clk = ~clk;

  acc_alu u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .src_i(src), .cy_i(cy),
    .a_o(a_o), .b_o(b_o), .cy_o(cy_o), .ov_o(ov_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic string op_tag(int o);
    case (o)
      0: return "R1";
      1: return "R2";
      2, 3, 4, 5, 6: return "R3";
      7, 8: return "R4";
      9, 10, 11, 12, 13: return "R5";
      14: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_edge();
    int s, r;
    e_done = 0;
    if (e_busy != 0) begin
      if (rem == 0) begin
        e_busy = 0; e_done = 1; e_cy = 0;
        if (m_op == 14) begin
          s = m_a * m_b; e_a = s & 255; e_b = s >> 8; e_ov = (s > 255);
        end else if (m_b == 0) begin
          e_a = 255; e_b = m_a; e_ov = 1;
        end else begin
          e_a = m_a / m_b; e_b = m_a % m_b; e_ov = 0;
        end
        tag = op_tag(m_op);
      end else begin
        rem--;
        tag = "R10";
      end
    end else if (start) begin
      tag = op_tag(op);
      if (op >= 14) begin
        e_busy = 1; rem = 3; m_op = op; m_a = a; m_b = b;
        tag = "R9";
      end else begin
        e_done = 1; e_b = b; e_cy = cy;
        case (op)
          0: begin s = a + src; e_a = s & 255; e_cy = s >> 8;
               e_ov = (a[7] == src[7]) && (s[7] != a[7]); end
          1: begin s = int'(a) - int'(src) - int'(cy); r = s & 255;
               e_a = r; e_cy = (s < 0); e_ov = (a[7] != src[7]) && (r[7] != a[7]); end
          2: e_a = a & src;
          3: e_a = a | src;
          4: e_a = a ^ src;
          5: e_a = (~a) & 255;
          6: e_a = 0;
          7: e_a = (a + 1) & 255;
          8: e_a = (a + 255) & 255;
          9: e_a = (a >> 1) | ((a & 1) << 7);
          10: e_a = ((a << 1) & 255) | (a >> 7);
          11: begin e_a = (a >> 1) | (int'(cy) << 7); e_cy = a & 1; end
          12: begin e_a = ((a << 1) & 255) | int'(cy); e_cy = a >> 7; end
          default: e_a = ((a & 15) << 4) | (a >> 4);
        endcase
      end
    end else if (e_busy == 0) tag = "R12";
  endtask

  task automatic compare();
    vectors++;
    if (int'(a_o) != e_a || int'(b_o) != e_b || int'(cy_o) != e_cy ||
        int'(ov_o) != e_ov || int'(busy_o) != e_busy || int'(done_o) != e_done) begin
      fails++;
      $display("FAIL %s: a=%h b=%h cy=%0d ov=%0d busy=%0d done=%0d exp a=%h b=%h cy=%0d ov=%0d busy=%0d done=%0d",
               tag, a_o, b_o, cy_o, ov_o, busy_o, done_o,
               e_a[7:0], e_b[7:0], e_cy, e_ov, e_busy, e_done);
    end
  endtask

  task automatic step(input bit st, input int o, input int av, input int bv,
                      input int sv, input bit c);
    start = st; op = 4'(o); a = 8'(av); b = 8'(bv); src = 8'(sv); cy = c;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h5A, 8'hA5, 8'h3C, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R11";
    compare();                               // R11 reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare();
    // R1 add with carry out and signed overflow
    step(1, 0, 8'hFF, 8'h11, 8'h01, 0);
    step(1, 0, 8'h7F, 8'h22, 8'h01, 0);
    // R2 subtract with borrow
    step(1, 1, 8'h05, 8'h00, 8'h03, 1);
    step(1, 1, 8'h00, 8'h00, 8'h01, 0);
    step(1, 1, 8'h80, 8'h00, 8'h01, 0);
    // R3 logic ops keep previous overflow
    step(1, 2, 8'hF0, 8'h01, 8'h3C, 1);
    step(1, 3, 8'hF0, 8'h01, 8'h0F, 0);
    step(1, 4, 8'hFF, 8'h01, 8'h0F, 1);
    step(1, 5, 8'hA5, 8'h01, 8'h00, 0);
    step(1, 6, 8'hA5, 8'h01, 8'h00, 1);
    // R4 inc/dec wrap
    step(1, 7, 8'hFF, 8'h02, 8'h00, 0);
    step(1, 8, 8'h00, 8'h02, 8'h00, 1);
    // R5 rotates and swap
    step(1, 9,  8'h81, 8'h03, 8'h00, 0);
    step(1, 10, 8'h81, 8'h03, 8'h00, 0);
    step(1, 11, 8'h01, 8'h03, 8'h00, 0);
    step(1, 12, 8'h80, 8'h03, 8'h00, 1);
    step(1, 13, 8'h3C, 8'h03, 8'h00, 0);
    // R7 multiply, R9 timing
    step(1, 14, 8'hFF, 8'hFF, 8'h00, 1); idle(5);
    step(1, 14, 8'h10, 8'h05, 8'h00, 1); idle(5);
    // R8 divide and divide by zero
    step(1, 15, 8'h95, 8'h10, 8'h00, 1); idle(5);
    step(1, 15, 8'h37, 8'h00, 8'h00, 1); idle(5);
    // R10 operands disturbed, start pulses while busy
    step(1, 15, 8'hC8, 8'h07, 8'h00, 0);
    for (int i = 0; i < 4; i++) step(1, i, 8'h11 * i, 8'h00, 8'h22, 1);
    step(1, 14, 8'h0C, 8'h0D, 8'h00, 0);
    for (int i = 0; i < 4; i++) step(1, 15, 8'hFF, 8'h01, 8'h00, 0);
    step(0, 0, 0, 0, 0, 0);
    // R12 hold with no start
    idle(4);
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 16, $urandom % 256,
           (($urandom % 8) == 0) ? 0 : $urandom % 256, $urandom % 256, $urandom % 2);
    finish_run();
  end
endmodule